// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading one entry from a flat page table that sits in memory. A requester hands it a virtual address, a read/write flag and the current table base. The walker then works out where the entry for that virtual page lives, issues a single memory read for it, and examines the returned word. If the entry is valid and grants the requested kind of access, the walker joins the entry's frame number to the untouched low twelve address bits. Otherwise it reports a fault code and no address.

The walker handles one translation at a time. It does not raise exceptions, move pages, cache translations or build tables. Software acts on the fault code. Every edge uses a valid/ready handshake, so the walker can sit between a load/store unit and a memory port that have arbitrary latency and back-pressure.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted, and right after it is released, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: The table read goes to `pt_base + 4 * vaddr[31:12]`, wrapping modulo 2^32. The base and the virtual address are both captured in the cycle the request is accepted, and later changes on `pt_base` or `req_vaddr` have no effect on the walk in progress.
- R3: Only one translation is in flight. `req_ready` is 1 only when no walk is active. A request is taken on `req_valid && req_ready`, and `mem_req_valid` rises on the next cycle. Each translation makes exactly one memory read. `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready` is seen.
- R4: An entry is a 32-bit word laid out as follows: bit 31 is valid, bit 30 grants read, bit 29 grants write, and bits 17:0 hold the frame number. Bits 28:18 are ignored.
- R5: A valid entry that grants the requested access gives `rsp_fault = 2'b00` and `rsp_paddr = {frame[17:0], vaddr[11:0]}`.
- R6: An entry whose valid bit is 0 gives `rsp_fault = 2'b01` (page fault) and `rsp_paddr = 0`, whatever its rights bits say.
- R7: A valid entry that lacks the needed right gives `rsp_fault = 2'b10` (protection fault) and `rsp_paddr = 0`. A write needs bit 29, and a read needs bit 30. The code 2'b11 is never produced.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response holds still. After the handshake, `rsp_valid` drops and `req_ready` returns on the next cycle.
- R9: `mem_rsp_valid` is only taken after the table read has been accepted. A memory response that arrives before that, or while a result waits to be taken, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker is idle and takes a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load access |
| pt_base | input | 32 | Byte address of the page table start |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry word returned |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 30 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that the idle state excludes both other outputs, that a fetch follows every accepted request, that a stalled read and a stalled response both hold still, that a response clears after its handshake, that a faulting response carries a zero address and a legal code, and that a successful address keeps the accepted offset. Several properties cannot be stated cycle by cycle and are shown only by the bench's scenarios: the exact entry address (including wrap-around), the decoding of the valid, read and write bits, the priority of page fault over protection fault, the indifference to bits 28:18, the single read per walk, and the insensitivity to stray inputs during a walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    // Sequencer states; the walk always visits them in this order.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_WAIT    = 2'd2,
        ST_RESPOND = 2'd3
    } walk_state_e;

    // Result code returned with every translation.
    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PAGE = 2'b01,
        FLT_PROT = 2'b10
    } fault_e;

endpackage

// File: rtl/pt_entry_addr.sv
// Byte address of the table entry that belongs to a virtual page.
module pt_entry_addr #(
    parameter int VA_W       = 32,
    parameter int VPN_W      = 20,
    parameter int ENTRY_LOG2 = 2
) (
    input  logic [VA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [VA_W-1:0]  entry_addr
);

    localparam int IDX_W = VPN_W + ENTRY_LOG2;

    logic [IDX_W-1:0] idx_bytes;
    assign idx_bytes = {vpn, {ENTRY_LOG2{1'b0}}};

    generate
        if (IDX_W >= VA_W) begin : g_trunc
            logic idx_unused;
            assign idx_unused = ^idx_bytes;
            assign entry_addr = base + idx_bytes[VA_W-1:0];
        end else begin : g_extend
            assign entry_addr = base + {{(VA_W-IDX_W){1'b0}}, idx_bytes};
        end
    endgenerate

endmodule

// File: rtl/pt_entry_check.sv
// Decodes a fetched entry and forms the translation result.
module pt_entry_check
    import pt_walker_pkg::*;
#(
    parameter int PTE_W     = 32,
    parameter int PPN_W     = 18,
    parameter int OFFSET_W  = 12,
    parameter int PA_W      = 30,
    parameter int VALID_POS = 31,
    parameter int RD_POS    = 30,
    parameter int WR_POS    = 29
) (
    input  logic [PTE_W-1:0]    pte,
    input  logic                is_write,
    input  logic [OFFSET_W-1:0] offset,
    output logic [PA_W-1:0]     paddr,
    output fault_e              fault
);

    logic ent_valid;
    logic ent_rd;
    logic ent_wr;
    logic right_ok;
    logic pte_unused;

    assign ent_valid  = pte[VALID_POS];
    assign ent_rd     = pte[RD_POS];
    assign ent_wr     = pte[WR_POS];
    assign right_ok   = is_write ? ent_wr : ent_rd;
    // Bits between the frame field and the rights bits carry no meaning.
    assign pte_unused = ^pte;

    always_comb begin
        fault = FLT_NONE;
        paddr = '0;
        if (!ent_valid) begin
            fault = FLT_PAGE;
        end else if (!right_ok) begin
            fault = FLT_PROT;
        end else begin
            paddr = {pte[PPN_W-1:0], offset};
        end
    end

endmodule

// File: rtl/pt_walk_seq.sv
// Request capture and IDLE -> FETCH -> WAIT -> RESPOND sequencing.
module pt_walk_seq
    import pt_walker_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PA_W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    input  logic [VA_W-1:0] pt_base,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] chk_paddr,
    input  fault_e          chk_fault,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [PA_W-1:0] rsp_paddr,
    output fault_e          rsp_fault,
    output logic [VA_W-1:0] vaddr_o,
    output logic [VA_W-1:0] base_o,
    output logic            write_o
);

    typedef struct packed {
        walk_state_e     st;
        logic [VA_W-1:0] vaddr;
        logic            wr;
        logic [VA_W-1:0] base;
        logic [PA_W-1:0] paddr;
        fault_e          fault;
    } walk_regs_t;

    walk_regs_t walk_d;
    walk_regs_t walk_q;

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.st    = ST_FETCH;
                    walk_d.vaddr = req_vaddr;
                    walk_d.wr    = req_write;
                    walk_d.base  = pt_base;
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) begin
                    walk_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    walk_d.st    = ST_RESPOND;
                    walk_d.paddr = chk_paddr;
                    walk_d.fault = chk_fault;
                end
            end
            ST_RESPOND: begin
                if (rsp_ready) begin
                    walk_d.st = ST_IDLE;
                end
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '{st: ST_IDLE, vaddr: '0, wr: 1'b0, base: '0,
                        paddr: '0, fault: FLT_NONE};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready     = (walk_q.st == ST_IDLE);
    assign mem_req_valid = (walk_q.st == ST_FETCH);
    assign rsp_valid     = (walk_q.st == ST_RESPOND);
    assign rsp_paddr     = walk_q.paddr;
    assign rsp_fault     = walk_q.fault;
    assign vaddr_o       = walk_q.vaddr;
    assign base_o        = walk_q.base;
    assign write_o       = walk_q.wr;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int OFFSET_W   = 12,
    parameter int PPN_W      = 18,
    parameter int PTE_W      = 32,
    parameter int ENTRY_LOG2 = 2,
    parameter int VALID_POS  = 31,
    parameter int RD_POS     = 30,
    parameter int WR_POS     = 29,
    localparam int VPN_W     = VA_W - OFFSET_W,
    localparam int PA_W      = PPN_W + OFFSET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic [VA_W-1:0]  pt_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [VA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault
);

    logic [VA_W-1:0] vaddr_q;
    logic [VA_W-1:0] base_q;
    logic            write_q;
    logic [PA_W-1:0] chk_paddr;
    fault_e          chk_fault;
    fault_e          rsp_fault_e;

    pt_walk_seq #(
        .VA_W (VA_W),
        .PA_W (PA_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .pt_base       (pt_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .chk_paddr     (chk_paddr),
        .chk_fault     (chk_fault),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault_e),
        .vaddr_o       (vaddr_q),
        .base_o        (base_q),
        .write_o       (write_q)
    );

    pt_entry_addr #(
        .VA_W       (VA_W),
        .VPN_W      (VPN_W),
        .ENTRY_LOG2 (ENTRY_LOG2)
    ) u_addr (
        .base       (base_q),
        .vpn        (vaddr_q[VA_W-1:OFFSET_W]),
        .entry_addr (mem_req_addr)
    );

    pt_entry_check #(
        .PTE_W     (PTE_W),
        .PPN_W     (PPN_W),
        .OFFSET_W  (OFFSET_W),
        .PA_W      (PA_W),
        .VALID_POS (VALID_POS),
        .RD_POS    (RD_POS),
        .WR_POS    (WR_POS)
    ) u_check (
        .pte      (mem_rsp_data),
        .is_write (write_q),
        .offset   (vaddr_q[OFFSET_W-1:0]),
        .paddr    (chk_paddr),
        .fault    (chk_fault)
    );

    assign rsp_fault = rsp_fault_e;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int VA_W     = 32,
    parameter int OFFSET_W = 12,
    parameter int PA_W     = 30
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [VA_W-1:0] mem_req_addr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault
);

    logic [OFFSET_W-1:0] seen_offset_q;
    logic                vaddr_unused;

    assign vaddr_unused = ^req_vaddr[VA_W-1:OFFSET_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_offset_q <= '0;
        end else if (req_valid && req_ready) begin
            seen_offset_q <= req_vaddr[OFFSET_W-1:0];
        end
    end

    AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !rsp_valid); // R3

    AST_ACCEPT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req_valid); // R3

    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R3

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R8

    AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> !rsp_valid && req_ready); // R8

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != 2'b00) |-> (rsp_paddr == '0)); // R6

    AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'b11)); // R7

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault == 2'b00) |-> (rsp_paddr[OFFSET_W-1:0] == seen_offset_q)); // R5

endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

    typedef struct packed {
        logic [31:0] vaddr;
        logic        wr;
        logic [31:0] base;
        logic [31:0] pte;
        logic [29:0] paddr;
        logic [1:0]  fault;
        logic [1:0]  mstall;
        logic [1:0]  lat;
        logic [1:0]  hold;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{32'h0000_40F3, 1'b0, 32'h0010_0000, 32'hC000_20C0, 30'h020C_00F3, 2'b00, 2'd0, 2'd0, 2'd0},
        '{32'h0000_40F3, 1'b1, 32'h0010_0000, 32'hC000_20C0, 30'h0,         2'b10, 2'd0, 2'd1, 2'd0},
        '{32'h0000_2082, 1'b0, 32'h0020_0000, 32'h6000_1234, 30'h0,         2'b01, 2'd1, 2'd0, 2'd2},
        '{32'h0000_2082, 1'b1, 32'h0020_0000, 32'h4000_0055, 30'h0,         2'b01, 2'd0, 2'd0, 2'd0},
        '{32'hFFFF_FFFF, 1'b1, 32'h0030_0000, 32'hE003_FFFF, 30'h3FFF_FFFF, 2'b00, 2'd2, 2'd2, 2'd1},
        '{32'h00AB_C010, 1'b0, 32'h0030_0000, 32'hA000_0777, 30'h0,         2'b10, 2'd0, 2'd0, 2'd0},
        '{32'h1234_5ABC, 1'b0, 32'h0040_0000, 32'hDFFC_0123, 30'h0012_3ABC, 2'b00, 2'd0, 2'd3, 2'd0},
        '{32'h0040_0004, 1'b1, 32'hFFFF_F000, 32'hA000_0001, 30'h0000_1004, 2'b00, 2'd3, 2'd0, 2'd3},
        '{32'h0000_5000, 1'b0, 32'h0000_0000, 32'h8000_0ABC, 30'h0,         2'b10, 2'd0, 2'd1, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] pt_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [29:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int checks = 0;
    int errors = 0;
    int mem_reads = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pt_walker u_dut (.*);

    always @(posedge clk) begin
        if (rst_n && mem_req_valid && mem_req_ready) mem_reads <= mem_reads + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_walk(input logic [31:0] vaddr, input logic wr, input logic [31:0] base,
                           input logic [31:0] pte, input logic [29:0] exp_pa,
                           input logic [1:0] exp_flt, input int mstall, input int lat,
                           input int hold);
        logic [31:0] exp_ea;
        int          reads_before;
        exp_ea = base + {vaddr[31:12], 2'b00};
        @(negedge clk);
        reads_before = mem_reads;
        check(req_ready === 1'b1, "R3 idle before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_vaddr = vaddr; req_write = wr; pt_base = base;
        mem_req_ready = (mstall == 0);
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_req_valid === 1'b1, "R3 fetch after accept", 32'(mem_req_valid), 32'd1);
        check(mem_req_addr === exp_ea, "R2 entry address", mem_req_addr, exp_ea);
        if (mstall > 0) begin
            for (int k = 0; k < mstall; k++) begin
                req_valid = 1'b1; req_vaddr = ~vaddr; req_write = ~wr;
                pt_base = base + 32'h0000_0100;
                mem_rsp_valid = 1'b1; mem_rsp_data = 32'hE000_0FFF;
                @(negedge clk);
                check(req_ready === 1'b0, "R3 busy refuses request", 32'(req_ready), 32'd0);
                check(mem_req_valid === 1'b1 && mem_req_addr === exp_ea,
                      "R2 stalled read keeps captured address", mem_req_addr, exp_ea);
            end
            req_valid = 1'b0; mem_rsp_valid = 1'b0; mem_req_ready = 1'b1;
            @(negedge clk);
        end else begin
            @(negedge clk);
        end
        check(mem_req_valid === 1'b0, "R3 read issued once", 32'(mem_req_valid), 32'd0);
        for (int k = 0; k < lat; k++) begin
            mem_rsp_valid = 1'b0;
            @(negedge clk);
            check(rsp_valid === 1'b0, "R9 no result before data", 32'(rsp_valid), 32'd0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 32'h0BAD_F00D;
        rsp_ready = (hold == 0);
        check(rsp_valid === 1'b1, "R8 result presented", 32'(rsp_valid), 32'd1);
        check(rsp_fault === exp_flt,
              exp_flt == 2'b00 ? "R5 fault code" : (exp_flt == 2'b01 ? "R6 fault code" : "R7 fault code"),
              32'(rsp_fault), 32'(exp_flt));
        check(rsp_paddr === exp_pa,
              exp_flt == 2'b00 ? "R5 physical address" : "R6/R7 zero address on fault",
              32'(rsp_paddr), 32'(exp_pa));
        for (int k = 0; k < hold; k++) begin
            mem_rsp_valid = 1'b1; mem_rsp_data = 32'hE003_FFFF;
            @(negedge clk);
            check(rsp_valid === 1'b1 && rsp_paddr === exp_pa && rsp_fault === exp_flt,
                  "R8 R9 held result", 32'(rsp_paddr), 32'(exp_pa));
        end
        mem_rsp_valid = 1'b0; rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(rsp_valid === 1'b0 && req_ready === 1'b1, "R8 release after handshake",
              {30'd0, rsp_valid, req_ready}, 32'd1);
        check(mem_reads - reads_before == 1, "R3 one memory read per walk",
              32'(mem_reads - reads_before), 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && mem_req_valid === 1'b0 && rsp_valid === 1'b0,
              "R1 outputs in reset", {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && mem_req_valid === 1'b0 && rsp_valid === 1'b0,
              "R1 outputs after reset", {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'h4);

        // Vector table: R2 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            do_walk(VECS[i].vaddr, VECS[i].wr, VECS[i].base, VECS[i].pte, VECS[i].paddr,
                    VECS[i].fault, int'(VECS[i].mstall), int'(VECS[i].lat), int'(VECS[i].hold));
        end

        // R7: valid entry with no rights, write access
        do_walk(32'h0000_5123, 1'b1, 32'h0000_0000, 32'h8000_0ABC, 30'h0, 2'b10, 0, 0, 0);
        // R4: junk in bits 28:18 with write right granted
        do_walk(32'h0000_1FFF, 1'b1, 32'h0000_8000, 32'hBFFC_0042, 30'h0004_2FFF, 2'b00, 1, 1, 1);

        // R1: reset in the middle of a walk returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_3000; req_write = 1'b0; pt_base = 32'h0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(req_ready === 1'b1 && mem_req_valid === 1'b0 && rsp_valid === 1'b0,
              "R1 mid-walk reset", {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
        @(negedge clk);
        rst_n = 1'b1;
        do_walk(32'h0000_40F3, 1'b0, 32'h0010_0000, 32'hC000_20C0, 30'h020C_00F3, 2'b00, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule